// File: doc/BRIEF.md
# Transmit Gather Copy Engine

This block assembles outgoing packets from one or more fragments that sit in host memory. Software issues one command per fragment, carrying a buffer address, a byte length and a continuation flag. For each command the engine waits until the transmit FIFO can hold the fragment on top of whatever the current packet has already gathered. It then runs a modelled DMA read of the fragment and adds the fragment's bytes to the packet under construction. The fragment that arrives without the continuation flag closes the packet, and the whole packet is committed to the transmit FIFO as one entry.

Every fragment ends with a completion word and a one-cycle transmit-data interrupt pulse. The FIFO holds packet lengths and tracks how many bytes it stores. When the wire side takes a packet, the FIFO raises a transmit-done cause, and also a low-water cause if few bytes are left after the take. If a packet cannot be committed (it is longer than the maximum packet size, or every FIFO entry is taken), a fault pulse is raised and nothing is stored.

The controller is a five-state machine: IDLE, FIFO_WAIT, BEGIN_COPY, COPY and COPY_DONE. IDLE moves to FIFO_WAIT when a command is written while transmit is enabled. FIFO_WAIT moves to BEGIN_COPY once the space test passes. BEGIN_COPY always moves to COPY, loading the DMA latency timer. COPY moves to COPY_DONE when that timer reaches zero. COPY_DONE always returns to IDLE.

Top module: `txg_gather_engine`

## Requirements
- R1: After reset the engine is idle (`busy` low), `done_word` is zero, the FIFO is empty (`fifo_used` zero, `pkt_avail` low) and every pulse output is low.
- R2: A command write while idle clears `done_word` at the next edge. If `tx_en` is high the engine leaves IDLE. If `tx_en` is low the engine stays idle, no DMA starts, nothing is stored, and raising `tx_en` later does not start it.
- R3: A command write while busy raises `cmd_err` for one cycle at the next edge. The write is otherwise ignored: the fragment in flight completes with its own length, and no further fragment is started.
- R4: In FIFO_WAIT the engine stalls, with `dma_rd_valid` low, until (FIFO_BYTES − `fifo_used`) − (bytes already gathered for the current packet) ≥ command length. An exact fit passes without delay.
- R5: The DMA latency is L = DMA_DLY + ceil(len/64) × DMA_FACTOR. `dma_rd_valid` is high for exactly L+1 cycles, with a stable address. `irq_txdata` rises 5+L clock edges after the edge that samples the command, counting that edge, when no stall occurs.
- R6: A fragment with `cmd_more` high adds its length to the gathered count and stores nothing. The `dma_rd_off` of the next fragment equals the sum of the earlier fragments of the packet.
- R7: A fragment with `cmd_more` low commits gathered + length as one FIFO entry, and the gathered count returns to zero. `fifo_used` grows by the packet length in the same edge as the completion pulse.
- R8: After every fragment, `done_word` holds bit LEN_W set (complete) and bits LEN_W−1:0 equal to the fragment length. `irq_txdata` pulses for one cycle and `busy` is low in that cycle.
- R9: A take (`pkt_pop` with `pkt_avail`) removes the head packet and pulses `irq_txdone` in the next cycle. `irq_txfifo` pulses in the same cycle only when `fifo_used` after the take is ≤ LOW_THR.
- R10: At commit, if the packet exceeds MAX_PKT or all DEPTH entries are taken, `commit_fault` pulses alongside `irq_txdata`. Nothing is stored, and the next packet starts at offset zero.
- R11: Packets leave the FIFO in commit order, and `pkt_len` shows the length of the head packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable; gates the start of a new command |
| cmd_wr | input | 1 | Command write strobe |
| cmd_addr | input | ADDR_W | Host address of the fragment |
| cmd_len | input | LEN_W | Fragment length in bytes |
| cmd_more | input | 1 | More fragments follow in this packet |
| dma_rd_valid | output | 1 | DMA read of the fragment in progress |
| dma_rd_addr | output | ADDR_W | DMA source address |
| dma_rd_len | output | LEN_W | DMA length in bytes |
| dma_rd_off | output | CNT_W | Byte offset of the fragment inside the packet |
| pkt_pop | input | 1 | Wire side takes the head packet |
| pkt_avail | output | 1 | FIFO holds at least one packet |
| pkt_len | output | LEN_W | Length of the head packet |
| fifo_used | output | CNT_W | Bytes stored in the FIFO |
| done_word | output | LEN_W+1 | Completion word: complete flag at bit LEN_W, fragment length below |
| busy | output | 1 | Engine is not idle |
| cmd_err | output | 1 | Command was written while busy |
| commit_fault | output | 1 | Packet could not be committed |
| irq_txdata | output | 1 | Fragment-complete interrupt cause |
| irq_txdone | output | 1 | Packet-taken interrupt cause |
| irq_txfifo | output | 1 | FIFO-low interrupt cause |

## Verification
The bench builds the block with MAX_PKT=200, FIFO_BYTES=256, DEPTH=4, LOW_THR=64, DMA_DLY=3 and DMA_FACTOR=2. With these values every single-fragment length from 0 to 200 can be swept one by one. That covers each 64-byte step of the latency formula and the exact MAX_PKT length. The small FIFO means a single large packet leaves too little room for the next fragment, so exact-fit and one-byte-short admission are both reachable. A stall caused only by gathered bytes is reachable too, as is running out of entries after four short packets. The low threshold sits between typical occupancies, so the low-water cause can be seen both firing and staying quiet.

// File: rtl/txg_pkg.sv
package txg_pkg;

    // Controller states, in the order a fragment walks through them
    typedef enum logic [2:0] {
        TXG_IDLE,
        TXG_FIFO_WAIT,
        TXG_BEGIN_COPY,
        TXG_COPY,
        TXG_COPY_DONE
    } txg_state_e;

    // DMA latency is counted per block of 2**TXG_BLK_SHIFT bytes
    localparam int TXG_BLK_SHIFT = 6;

endpackage

// File: rtl/txg_dma_timer.sv
module txg_dma_timer
    import txg_pkg::*;
#(
    parameter int LEN_W      = 15,
    parameter int LAT_W      = 16,
    parameter int DMA_DLY    = 10,
    parameter int DMA_FACTOR = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    output logic             zero
);

    localparam int BLK_MASK = (1 << TXG_BLK_SHIFT) - 1;

    logic [LEN_W:0]   rounded;
    logic [LEN_W:0]   blocks;
    logic [LAT_W-1:0] lat;
    logic [LAT_W-1:0] cnt;

    // Round the length up to whole blocks, then scale by the per-block cost
    assign rounded = {1'b0, len} + (LEN_W+1)'(BLK_MASK);
    assign blocks  = rounded >> TXG_BLK_SHIFT;
    assign lat     = LAT_W'(DMA_DLY) + LAT_W'(blocks) * LAT_W'(DMA_FACTOR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= lat;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/txg_len_fifo.sv
module txg_len_fifo #(
    parameter int DEPTH   = 8,
    parameter int LEN_W   = 15,
    parameter int CNT_W   = 16,
    parameter int LOW_THR = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LEN_W-1:0] push_len,
    input  logic             pop_req,
    output logic [LEN_W-1:0] head_len,
    output logic             head_valid,
    output logic             slots_full,
    output logic [CNT_W-1:0] used_bytes,
    output logic             irq_txdone,
    output logic             irq_txfifo
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NUM_W = $clog2(DEPTH + 1);

    logic [LEN_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;
    logic [NUM_W-1:0] num;
    logic             push_fire;
    logic             pop_fire;
    logic [CNT_W-1:0] used_next;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) begin
            return '0;
        end
        return p + 1'b1;
    endfunction

    assign slots_full = (num == NUM_W'(DEPTH));
    assign head_valid = (num != '0);
    assign head_len   = mem[rd_ptr];
    assign push_fire  = push && !slots_full;
    assign pop_fire   = pop_req && head_valid;

    always_comb begin
        used_next = used_bytes;
        if (push_fire) begin
            used_next = used_next + CNT_W'(push_len);
        end
        if (pop_fire) begin
            used_next = used_next - CNT_W'(head_len);
        end
    end

    always_ff @(posedge clk) begin
        if (push_fire) begin
            mem[wr_ptr] <= push_len;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr     <= '0;
            wr_ptr     <= '0;
            num        <= '0;
            used_bytes <= '0;
            irq_txdone <= 1'b0;
            irq_txfifo <= 1'b0;
        end else begin
            if (push_fire) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop_fire) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({push_fire, pop_fire})
                2'b10:   num <= num + 1'b1;
                2'b01:   num <= num - 1'b1;
                default: num <= num;
            endcase
            used_bytes <= used_next;
            irq_txdone <= pop_fire;
            irq_txfifo <= pop_fire && (used_next <= CNT_W'(LOW_THR));
        end
    end

endmodule

// File: rtl/txg_seq_ctrl.sv
module txg_seq_ctrl
    import txg_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 15,
    parameter int CNT_W   = 16,
    parameter int MAX_PKT = 16384
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              cmd_wr,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_more,
    input  logic [CNT_W-1:0]  free_bytes,
    input  logic              slots_full,
    input  logic              tmr_zero,
    output logic              tmr_load,
    output logic              push,
    output logic [LEN_W-1:0]  push_len,
    output logic              dma_valid,
    output logic [ADDR_W-1:0] dma_addr,
    output logic [LEN_W-1:0]  dma_len,
    output logic [CNT_W-1:0]  dma_off,
    output logic [LEN_W:0]    done_word,
    output logic              busy,
    output logic              cmd_err,
    output logic              commit_fault,
    output logic              irq_txdata
);

    txg_state_e state_q;
    txg_state_e state_d;

    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic              more_q;
    logic [CNT_W-1:0]  gathered_q;
    logic [CNT_W:0]    total;
    logic              space_ok;
    logic              commit_ok;

    // Bytes the packet will hold once this fragment lands
    assign total     = {1'b0, gathered_q} + (CNT_W+1)'(len_q);
    assign space_ok  = ({1'b0, free_bytes} >= total);
    assign commit_ok = !slots_full && (total <= (CNT_W+1)'(MAX_PKT));

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXG_IDLE:       if (cmd_wr && tx_en) state_d = TXG_FIFO_WAIT;
            TXG_FIFO_WAIT:  if (space_ok)        state_d = TXG_BEGIN_COPY;
            TXG_BEGIN_COPY:                      state_d = TXG_COPY;
            TXG_COPY:       if (tmr_zero)        state_d = TXG_COPY_DONE;
            TXG_COPY_DONE:                       state_d = TXG_IDLE;
            default:                             state_d = TXG_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TXG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        busy      = (state_q != TXG_IDLE);
        tmr_load  = (state_q == TXG_BEGIN_COPY);
        dma_valid = (state_q == TXG_COPY);
        push      = (state_q == TXG_COPY_DONE) && !more_q && commit_ok;
        push_len  = LEN_W'(total);
        dma_addr  = addr_q;
        dma_len   = len_q;
        dma_off   = gathered_q;
    end

    // Command capture, gathered length and completion reporting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q       <= '0;
            len_q        <= '0;
            more_q       <= 1'b0;
            gathered_q   <= '0;
            done_word    <= '0;
            cmd_err      <= 1'b0;
            commit_fault <= 1'b0;
            irq_txdata   <= 1'b0;
        end else begin
            cmd_err      <= 1'b0;
            commit_fault <= 1'b0;
            irq_txdata   <= 1'b0;
            if (cmd_wr) begin
                if (state_q != TXG_IDLE) begin
                    cmd_err <= 1'b1;
                end else begin
                    addr_q    <= cmd_addr;
                    len_q     <= cmd_len;
                    more_q    <= cmd_more;
                    done_word <= '0;
                end
            end
            if (state_q == TXG_COPY_DONE) begin
                done_word  <= {1'b1, len_q};
                irq_txdata <= 1'b1;
                if (more_q) begin
                    gathered_q <= gathered_q + CNT_W'(len_q);
                end else begin
                    gathered_q   <= '0;
                    commit_fault <= !commit_ok;
                end
            end
        end
    end

endmodule

// File: rtl/txg_gather_engine.sv
module txg_gather_engine #(
    parameter int ADDR_W     = 32,
    parameter int MAX_PKT    = 16384,
    parameter int FIFO_BYTES = 32768,
    parameter int DEPTH      = 8,
    parameter int LOW_THR    = 4096,
    parameter int DMA_DLY    = 10,
    parameter int DMA_FACTOR = 4,
    parameter int LAT_W      = 16,
    localparam int LEN_W     = $clog2(MAX_PKT + 1),
    localparam int CNT_W     = $clog2(FIFO_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              cmd_wr,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_more,
    output logic              dma_rd_valid,
    output logic [ADDR_W-1:0] dma_rd_addr,
    output logic [LEN_W-1:0]  dma_rd_len,
    output logic [CNT_W-1:0]  dma_rd_off,
    input  logic              pkt_pop,
    output logic              pkt_avail,
    output logic [LEN_W-1:0]  pkt_len,
    output logic [CNT_W-1:0]  fifo_used,
    output logic [LEN_W:0]    done_word,
    output logic              busy,
    output logic              cmd_err,
    output logic              commit_fault,
    output logic              irq_txdata,
    output logic              irq_txdone,
    output logic              irq_txfifo
);

    logic             tmr_load;
    logic             tmr_zero;
    logic             push;
    logic [LEN_W-1:0] push_len;
    logic             slots_full;
    logic [CNT_W-1:0] free_bytes;

    assign free_bytes = CNT_W'(FIFO_BYTES) - fifo_used;

    txg_seq_ctrl #(
        .ADDR_W  (ADDR_W),
        .LEN_W   (LEN_W),
        .CNT_W   (CNT_W),
        .MAX_PKT (MAX_PKT)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_en        (tx_en),
        .cmd_wr       (cmd_wr),
        .cmd_addr     (cmd_addr),
        .cmd_len      (cmd_len),
        .cmd_more     (cmd_more),
        .free_bytes   (free_bytes),
        .slots_full   (slots_full),
        .tmr_zero     (tmr_zero),
        .tmr_load     (tmr_load),
        .push         (push),
        .push_len     (push_len),
        .dma_valid    (dma_rd_valid),
        .dma_addr     (dma_rd_addr),
        .dma_len      (dma_rd_len),
        .dma_off      (dma_rd_off),
        .done_word    (done_word),
        .busy         (busy),
        .cmd_err      (cmd_err),
        .commit_fault (commit_fault),
        .irq_txdata   (irq_txdata)
    );

    txg_dma_timer #(
        .LEN_W      (LEN_W),
        .LAT_W      (LAT_W),
        .DMA_DLY    (DMA_DLY),
        .DMA_FACTOR (DMA_FACTOR)
    ) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .len   (dma_rd_len),
        .zero  (tmr_zero)
    );

    txg_len_fifo #(
        .DEPTH   (DEPTH),
        .LEN_W   (LEN_W),
        .CNT_W   (CNT_W),
        .LOW_THR (LOW_THR)
    ) fifo_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_len   (push_len),
        .pop_req    (pkt_pop),
        .head_len   (pkt_len),
        .head_valid (pkt_avail),
        .slots_full (slots_full),
        .used_bytes (fifo_used),
        .irq_txdone (irq_txdone),
        .irq_txfifo (irq_txfifo)
    );

endmodule

// File: rtl/txg_gather_engine_chk.sv
module txg_gather_engine_chk #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 15,
    parameter int CNT_W      = 16,
    parameter int FIFO_BYTES = 32768
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_wr,
    input logic              busy,
    input logic              cmd_err,
    input logic [LEN_W:0]    done_word,
    input logic              irq_txdata,
    input logic              irq_txdone,
    input logic              irq_txfifo,
    input logic              pkt_pop,
    input logic              pkt_avail,
    input logic [CNT_W-1:0]  fifo_used,
    input logic              commit_fault,
    input logic              dma_rd_valid,
    input logic [ADDR_W-1:0] dma_rd_addr
);

    AST_CMD_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && !busy |=> done_word == '0); // R2

    AST_BUSY_CMD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && busy |=> cmd_err); // R3

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_used <= CNT_W'(FIFO_BYTES)); // R4

    AST_DMA_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rd_valid && $past(dma_rd_valid) |-> $stable(dma_rd_addr)); // R5

    AST_DONE_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        irq_txdata |-> done_word[LEN_W] && !busy); // R8

    AST_TAKE_RAISES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_pop && pkt_avail |=> irq_txdone); // R9

    AST_LOW_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_txfifo |-> irq_txdone); // R9

    AST_FAULT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        commit_fault && !$past(pkt_pop && pkt_avail) |-> fifo_used == $past(fifo_used)); // R10

endmodule

bind txg_gather_engine txg_gather_engine_chk #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .CNT_W      (CNT_W),
    .FIFO_BYTES (FIFO_BYTES)
) chk_i (.*);

// File: tb/txg_gather_engine_tb.sv
`timescale 1ns/1ps
module txg_gather_engine_tb_top;

    localparam int ADDR_W = 32;
    localparam int MAXP   = 200;
    localparam int FBYTES = 256;
    localparam int DEP    = 4;
    localparam int LTHR   = 64;
    localparam int DLY    = 3;
    localparam int FAC    = 2;
    localparam int LW     = $clog2(MAXP + 1);
    localparam int CW     = $clog2(FBYTES + 1);
    localparam int CPL    = 1 << LW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tx_en = 1'b0;
    logic              cmd_wr = 1'b0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [LW-1:0]     cmd_len = '0;
    logic              cmd_more = 1'b0;
    logic              pkt_pop = 1'b0;
    logic              dma_rd_valid;
    logic [ADDR_W-1:0] dma_rd_addr;
    logic [LW-1:0]     dma_rd_len;
    logic [CW-1:0]     dma_rd_off;
    logic              pkt_avail;
    logic [LW-1:0]     pkt_len;
    logic [CW-1:0]     fifo_used;
    logic [LW:0]       done_word;
    logic              busy;
    logic              cmd_err;
    logic              commit_fault;
    logic              irq_txdata;
    logic              irq_txdone;
    logic              irq_txfifo;

    int nchk = 0;
    int nbad = 0;

    always #10 clk = ~clk;

    txg_gather_engine #(
        .ADDR_W(ADDR_W), .MAX_PKT(MAXP), .FIFO_BYTES(FBYTES), .DEPTH(DEP),
        .LOW_THR(LTHR), .DMA_DLY(DLY), .DMA_FACTOR(FAC), .LAT_W(16)
    ) dut_i (.*);

    function automatic int exp_lat(input int len);
        return DLY + ((len + 63) / 64) * FAC;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic issue(input int addr, input int len, input bit more);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_addr = ADDR_W'(addr); cmd_len = LW'(len); cmd_more = more;
        @(posedge clk); #1;
        cmd_wr = 1'b0;
    endtask

    // Issue one fragment and wait for its completion pulse
    task automatic frag(input int len, input bit more, output int cyc, output int vcnt,
                        output int off0, output int flt);
        issue(32'h1000 + len, len, more);
        cyc = 1; vcnt = 0; off0 = -1;
        while (!irq_txdata && cyc < 3000) begin
            if (dma_rd_valid) begin
                if (off0 < 0) off0 = int'(dma_rd_off);
                vcnt++;
            end
            @(posedge clk); #1;
            cyc++;
        end
        flt = int'(commit_fault);
    endtask

    task automatic wait_done(output int flt);
        int n = 0;
        while (!irq_txdata && n < 3000) begin
            @(posedge clk); #1;
            n++;
        end
        flt = int'(commit_fault);
    endtask

    task automatic take(output int dn, output int low);
        @(negedge clk);
        pkt_pop = 1'b1;
        @(posedge clk); #1;
        dn = int'(irq_txdone); low = int'(irq_txfifo);
        pkt_pop = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nbad++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        int cyc, vc, off, flt, dn, low;
        bit saw;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "done_word", int'(done_word), 0);
        chk("R1", "fifo_used", int'(fifo_used), 0);
        chk("R1", "pkt_avail", int'(pkt_avail), 0);
        chk("R1", "pulses", int'({irq_txdata, irq_txdone, irq_txfifo, cmd_err, commit_fault}), 0);
        tx_en = 1'b1;

        // Sweep every single-fragment length
        for (int len = 0; len <= MAXP; len++) begin
            frag(len, 1'b0, cyc, vc, off, flt);
            chk("R5", "cycles to completion", cyc, 5 + exp_lat(len));
            chk("R5", "dma valid cycles", vc, exp_lat(len) + 1);
            chk("R8", "done_word", int'(done_word), CPL + len);
            chk("R10", "no fault within limit", flt, 0);
            chk("R7", "fifo_used after commit", int'(fifo_used), len);
            chk("R11", "head length", int'(pkt_len), len);
            take(dn, low);
            chk("R9", "txdone pulse", dn, 1);
            chk("R9", "txfifo pulse at empty", low, 1);
            chk("R9", "fifo empty after take", int'(fifo_used), 0);
        end

        // Multi-fragment gather
        frag(30, 1'b1, cyc, vc, off, flt);
        chk("R6", "offset frag0", off, 0);
        chk("R6", "nothing stored", int'(fifo_used), 0);
        chk("R6", "no packet", int'(pkt_avail), 0);
        frag(40, 1'b1, cyc, vc, off, flt);
        chk("R6", "offset frag1", off, 30);
        chk("R6", "still nothing stored", int'(fifo_used), 0);
        frag(50, 1'b0, cyc, vc, off, flt);
        chk("R6", "offset frag2", off, 70);
        chk("R8", "done_word last frag", int'(done_word), CPL + 50);
        chk("R7", "packet stored", int'(fifo_used), 120);
        chk("R7", "packet length", int'(pkt_len), 120);
        frag(100, 1'b0, cyc, vc, off, flt);
        chk("R7", "gathered reset", off, 0);
        chk("R7", "two packets", int'(fifo_used), 220);
        take(dn, low);
        chk("R9", "txdone", dn, 1);
        chk("R9", "no low cause above threshold", low, 0);
        chk("R11", "next head", int'(pkt_len), 100);
        take(dn, low);
        chk("R9", "low cause at empty", low, 1);

        // Exact fit and one byte short
        frag(200, 1'b0, cyc, vc, off, flt);
        frag(56, 1'b0, cyc, vc, off, flt);
        chk("R4", "exact fit no stall", cyc, 5 + exp_lat(56));
        chk("R4", "full fifo", int'(fifo_used), 256);
        take(dn, low);
        take(dn, low);
        frag(200, 1'b0, cyc, vc, off, flt);
        issue(32'h2000, 57, 1'b0);
        saw = 1'b0;
        for (int i = 0; i < 30; i++) begin
            if (dma_rd_valid || irq_txdata) saw = 1'b1;
            @(posedge clk); #1;
        end
        chk("R4", "stalled busy", int'(busy), 1);
        chk("R4", "no dma during stall", int'(saw), 0);
        take(dn, low);
        wait_done(flt);
        chk("R4", "resumed done_word", int'(done_word), CPL + 57);
        chk("R4", "stored after resume", int'(fifo_used), 57);
        take(dn, low);

        // Stall caused by gathered bytes alone
        frag(100, 1'b0, cyc, vc, off, flt);
        frag(100, 1'b1, cyc, vc, off, flt);
        issue(32'h3000, 60, 1'b0);
        saw = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (dma_rd_valid) saw = 1'b1;
            @(posedge clk); #1;
        end
        chk("R4", "gathered stall no dma", int'(saw), 0);
        chk("R4", "gathered stall busy", int'(busy), 1);
        take(dn, low);
        wait_done(flt);
        chk("R4", "gathered packet stored", int'(fifo_used), 160);
        chk("R11", "gathered packet length", int'(pkt_len), 160);
        take(dn, low);

        // Oversize packet
        frag(150, 1'b1, cyc, vc, off, flt);
        frag(100, 1'b0, cyc, vc, off, flt);
        chk("R10", "oversize fault", flt, 1);
        chk("R10", "oversize not stored", int'(fifo_used), 0);
        chk("R10", "oversize no packet", int'(pkt_avail), 0);
        chk("R8", "done_word on fault", int'(done_word), CPL + 100);

        // Entries exhausted
        for (int k = 0; k < DEP; k++) begin
            frag(10 + k, 1'b0, cyc, vc, off, flt);
            chk("R10", "fill no fault", flt, 0);
        end
        frag(14, 1'b0, cyc, vc, off, flt);
        chk("R10", "slots full fault", flt, 1);
        chk("R10", "slots full not stored", int'(fifo_used), 46);
        for (int k = 0; k < DEP; k++) begin
            chk("R11", "commit order", int'(pkt_len), 10 + k);
            take(dn, low);
        end
        frag(20, 1'b0, cyc, vc, off, flt);
        chk("R10", "offset zero after fault", off, 0);
        take(dn, low);

        // Command while busy
        issue(32'h4000, 100, 1'b0);
        repeat (3) @(posedge clk);
        issue(32'h5000, 5, 1'b0);
        chk("R3", "cmd_err pulse", int'(cmd_err), 1);
        wait_done(flt);
        chk("R3", "original completes", int'(done_word), CPL + 100);
        repeat (10) @(posedge clk);
        #1;
        chk("R3", "ignored cmd not started", int'(busy), 0);
        chk("R3", "only one packet", int'(fifo_used), 100);
        take(dn, low);

        // Transmit disabled
        tx_en = 1'b0;
        issue(32'h6000, 7, 1'b0);
        chk("R2", "done_word cleared", int'(done_word), 0);
        chk("R2", "stays idle", int'(busy), 0);
        repeat (15) @(posedge clk);
        #1;
        chk("R2", "nothing stored", int'(fifo_used), 0);
        tx_en = 1'b1;
        repeat (15) @(posedge clk);
        #1;
        chk("R2", "enable does not start", int'(busy), 0);
        chk("R2", "no dma", int'(dma_rd_valid), 0);

        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

endmodule